// File: doc/BRIEF.md
# Interrupt-Wake Sleep Controller

This block sequences a processor core into and out of its standard sleep state. Software sets a sleep-request bit. The request is taken only when the core clock is reported as running. Once the request is taken, the block halts the core. Only the interrupt-detection path stays alive, and it runs on the always-on clock `clk_i`. A synchronised interrupt brings the core back to execution. The request bit clears itself at that point. The PLL-enable and slow-clock-select settings are held unchanged through the whole sleep period, so the core resumes in the configuration it had before it slept.

While the core is asleep, an external stop pin can also cut the core clock. When the pin is released, the clock enable returns and the block goes back to sleep. It does not resume execution. Sleep works the same way whether the slow clock or the fast clock is selected. The interrupt and stop inputs are asynchronous and pass through a synchroniser with `SYNC_STAGES` stages. The default is two stages.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: During and just after reset: `mode_o`=2'b00, `core_halt_o`=0, `core_clk_en_o`=1, `sleep_bit_o`=0, `pll_en_o`=0, `clk_slow_o`=0, `wake_o`=0.
- R2: In RUN (`mode_o`=2'b00), a cycle with `sleep_wr_i`=1, `sleep_wdata_i`=1 and `clk_running_i`=1 moves the block to SLEEP (`mode_o`=2'b01) at the next clock edge. From that edge `core_halt_o`=1 and `sleep_bit_o`=1.
- R3: A sleep write made while `clk_running_i`=0 is ignored: `mode_o` stays 2'b00 and `sleep_bit_o` stays 0.
- R4: In SLEEP, `irq_i` held high returns the block to RUN on the third clock edge after it rises (two synchroniser edges plus one state edge). `wake_o` is 1 for exactly the cycle after that edge.
- R5: `sleep_bit_o` clears on the same edge as the interrupt wake.
- R6: A configuration write (`cfg_wr_i`) is ignored while `mode_o`≠2'b00. `pll_en_o` and `clk_slow_o` therefore keep their pre-sleep values through sleep and after wake.
- R7: In SLEEP, `stop_i` held high (with no interrupt) gives `mode_o`=2'b10 and `core_clk_en_o`=0 on the third edge after it rises. `core_halt_o` stays 1.
- R8: In the clock-stopped mode, `irq_i` has no effect. Releasing `stop_i` gives `mode_o`=2'b01 on the third edge after the release, never 2'b00.
- R9: Sleep entry works the same with `clk_slow_o`=1 as with `clk_slow_o`=0.
- R10: When synchronised interrupt and stop both reach SLEEP in the same cycle, the interrupt wins and the block goes to RUN.
- R11: In RUN, a sleep write with `sleep_wdata_i`=0, or an interrupt, leaves `mode_o` at 2'b00.
- R12: In RUN, `stop_i` has no effect: `mode_o` stays 2'b00 and `core_clk_en_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_wr_i | input | 1 | Write strobe for the sleep-request bit |
| sleep_wdata_i | input | 1 | Value written to the sleep-request bit |
| cfg_wr_i | input | 1 | Write strobe for the clock configuration |
| cfg_pll_en_i | input | 1 | PLL-enable value to write |
| cfg_slow_i | input | 1 | Slow-clock-select value to write |
| clk_running_i | input | 1 | Core clock is running |
| irq_i | input | 1 | Asynchronous interrupt request |
| stop_i | input | 1 | Asynchronous external clock-stop pin |
| core_halt_o | output | 1 | Core execution halted |
| core_clk_en_o | output | 1 | Core clock gate enable |
| mode_o | output | 2 | 00 run, 01 sleep, 10 sleep with clock stopped |
| sleep_bit_o | output | 1 | Sleep-request bit readback |
| pll_en_o | output | 1 | PLL enable |
| clk_slow_o | output | 1 | Slow clock select |
| wake_o | output | 1 | One-cycle pulse after an interrupt wake |

## Verification
The bench attempts sleep entry with the core clock reported as stopped. A design that skipped this check would halt a core that can never be woken.

It also raises stop and interrupt together. A design with the wrong priority would cut the clock instead of resuming execution.

It releases the stop pin while an interrupt has been seen. A design that treated the release as a wake, or that latched the interrupt while the clock was stopped, would return to RUN instead of SLEEP.

Finally, it writes the configuration during sleep and checks the exact wake latency. A leaky hold shows up as a changed PLL-enable or clock-select value, and a missing or extra synchroniser stage shows up as a wake one cycle early or late.

// File: rtl/sleep_wake_pkg.sv
package sleep_wake_pkg;
  localparam int unsigned MODE_W = 2;
  typedef enum logic [MODE_W-1:0] {
    MODE_RUN     = 2'b00,
    MODE_SLEEP   = 2'b01,
    MODE_STOPPED = 2'b10
  } mode_e;
endpackage

// File: rtl/sw_sync.sv
module sw_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else if (STAGES == 1) chain_q <= d_i[b];
      else chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[LAST];
  end
endmodule

// File: rtl/sw_mode_fsm.sv
module sw_mode_fsm
  import sleep_wake_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sleep_wr_i,
  input  logic  sleep_wdata_i,
  input  logic  clk_running_i,
  input  logic  irq_i,
  input  logic  stop_i,
  output mode_e mode_o,
  output logic  enter_o,
  output logic  wake_o,
  output logic  wake_pulse_o
);
  mode_e mode_q, mode_d;
  logic  wake_q;

  // request only counts from RUN with a live core clock
  assign enter_o = (mode_q == MODE_RUN) && sleep_wr_i && sleep_wdata_i && clk_running_i;
  assign wake_o  = (mode_q == MODE_SLEEP) && irq_i;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN:     if (enter_o) mode_d = MODE_SLEEP;
      MODE_SLEEP:   if (irq_i) mode_d = MODE_RUN;
                    else if (stop_i) mode_d = MODE_STOPPED;
      MODE_STOPPED: if (!stop_i) mode_d = MODE_SLEEP;
      default:      mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RUN;
      wake_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      wake_q <= wake_o;
    end
  end

  assign mode_o       = mode_q;
  assign wake_pulse_o = wake_q;

  AST_SLEEP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RUN && sleep_wr_i && sleep_wdata_i && clk_running_i) |=> (mode_q == MODE_SLEEP)); // R2
  AST_IRQ_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SLEEP && irq_i) |=> (mode_q == MODE_RUN && wake_q)); // R4
  AST_STOP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SLEEP && stop_i && !irq_i) |=> (mode_q == MODE_STOPPED)); // R7
  AST_STOP_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STOPPED) |=> (mode_q != MODE_RUN)); // R8
  AST_RUN_STOP_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RUN) |=> (mode_q != MODE_STOPPED)); // R12
endmodule

// File: rtl/sw_ctl_regs.sv
module sw_ctl_regs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic enter_i,
  input  logic wake_i,
  input  logic cfg_wr_i,
  input  logic cfg_pll_en_i,
  input  logic cfg_slow_i,
  output logic sleep_bit_o,
  output logic pll_en_o,
  output logic clk_slow_o
);
  logic sleep_q, pll_q, slow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sleep_q <= 1'b0;
    else if (wake_i) sleep_q <= 1'b0;
    else if (enter_i) sleep_q <= 1'b1;
  end

  // clock config frozen whenever the core is halted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pll_q  <= 1'b0;
      slow_q <= 1'b0;
    end else if (run_i && cfg_wr_i) begin
      pll_q  <= cfg_pll_en_i;
      slow_q <= cfg_slow_i;
    end
  end

  assign sleep_bit_o = sleep_q;
  assign pll_en_o    = pll_q;
  assign clk_slow_o  = slow_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i) |=> $stable({pll_q, slow_q})); // R6
  AST_SLEEP_BIT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> !sleep_q); // R5
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import sleep_wake_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_wr_i,
  input  logic              sleep_wdata_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_pll_en_i,
  input  logic              cfg_slow_i,
  input  logic              clk_running_i,
  input  logic              irq_i,
  input  logic              stop_i,
  output logic              core_halt_o,
  output logic              core_clk_en_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              sleep_bit_o,
  output logic              pll_en_o,
  output logic              clk_slow_o,
  output logic              wake_o
);
  localparam int unsigned N_ASYNC = 2;

  logic [N_ASYNC-1:0] async_raw, async_sync;
  logic  irq_s, stop_s, enter, wake_evt;
  mode_e mode;

  assign async_raw = {stop_i, irq_i};
  assign {stop_s, irq_s} = async_sync;

  sw_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (async_raw),
    .q_o    (async_sync)
  );

  sw_mode_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sleep_wr_i    (sleep_wr_i),
    .sleep_wdata_i (sleep_wdata_i),
    .clk_running_i (clk_running_i),
    .irq_i         (irq_s),
    .stop_i        (stop_s),
    .mode_o        (mode),
    .enter_o       (enter),
    .wake_o        (wake_evt),
    .wake_pulse_o  (wake_o)
  );

  sw_ctl_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (mode == MODE_RUN),
    .enter_i      (enter),
    .wake_i       (wake_evt),
    .cfg_wr_i     (cfg_wr_i),
    .cfg_pll_en_i (cfg_pll_en_i),
    .cfg_slow_i   (cfg_slow_i),
    .sleep_bit_o  (sleep_bit_o),
    .pll_en_o     (pll_en_o),
    .clk_slow_o   (clk_slow_o)
  );

  assign mode_o        = mode;
  assign core_halt_o   = (mode != MODE_RUN);
  assign core_clk_en_o = (mode != MODE_STOPPED);

  AST_REJECT_NO_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b00 && sleep_wr_i && !clk_running_i) |=> (mode_o == 2'b00 && !sleep_bit_o)); // R3
  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b11); // R1
  AST_GATED_IS_HALTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_clk_en_o |-> core_halt_o); // R7
  AST_HALT_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_halt_o && !$past(core_halt_o)) |-> sleep_bit_o); // R2
endmodule

// File: tb/sleep_wake_ctrl_tb.sv
module sleep_wake_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_wr = 0, sleep_wdata = 0, cfg_wr = 0, cfg_pll = 0, cfg_slow = 0;
  logic clk_run = 1, irq = 0, stop = 0;
  logic halt, clk_en, sb, pll, slow, wake;
  logic [1:0] mode;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [1:0] mode;
    logic sb, pll, slow, wake;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;  // 250 MHz

  sleep_wake_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_wr_i(sleep_wr), .sleep_wdata_i(sleep_wdata),
    .cfg_wr_i(cfg_wr), .cfg_pll_en_i(cfg_pll), .cfg_slow_i(cfg_slow),
    .clk_running_i(clk_run), .irq_i(irq), .stop_i(stop),
    .core_halt_o(halt), .core_clk_en_o(clk_en), .mode_o(mode), .sleep_bit_o(sb),
    .pll_en_o(pll), .clk_slow_o(slow), .wake_o(wake)
  );

  function automatic void chk(bit ok, string tag, string act, string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %s expected %s", tag, act, exp);
    end
  endfunction

  // driver: one clock edge, then queue the expected outputs
  task automatic tick(logic [1:0] m, logic s, logic p, logic sl, logic w, string tag);
    exp_t e;
    @(posedge clk);
    #1;
    e = '{mode: m, sb: s, pll: p, slow: sl, wake: w};
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      logic  eh, ec;
      e  = exp_q.pop_front();
      t  = tag_q.pop_front();
      eh = (e.mode != 2'b00);
      ec = (e.mode != 2'b10);
      chk({mode, sb, pll, slow, wake, halt, clk_en} == {e.mode, e.sb, e.pll, e.slow, e.wake, eh, ec}, t,
          $sformatf("mode=%b sb=%b pll=%b slow=%b wake=%b halt=%b clken=%b", mode, sb, pll, slow, wake, halt, clk_en),
          $sformatf("mode=%b sb=%b pll=%b slow=%b wake=%b halt=%b clken=%b", e.mode, e.sb, e.pll, e.slow, e.wake, eh, ec));
    end
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({mode, halt, clk_en, sb, pll, slow, wake} == 8'b00_0_1_0_0_0_0, "R1 in reset",
        $sformatf("%b", {mode, halt, clk_en, sb, pll, slow, wake}), "00010000");
    rst_n = 1'b1;
    tick(2'b00, 0, 0, 0, 0, "R1 after reset");

    cfg_wr = 1; cfg_pll = 1; cfg_slow = 0;
    tick(2'b00, 0, 1, 0, 0, "R6 cfg write in run");
    cfg_wr = 0;

    clk_run = 0; sleep_wr = 1; sleep_wdata = 1;
    tick(2'b00, 0, 1, 0, 0, "R3 sleep refused without clock");
    sleep_wr = 0; clk_run = 1;
    tick(2'b00, 0, 1, 0, 0, "R3 still run");

    sleep_wr = 1; sleep_wdata = 0;
    tick(2'b00, 0, 1, 0, 0, "R11 write of zero");
    sleep_wr = 0;
    irq = 1;
    for (int i = 0; i < 3; i++) tick(2'b00, 0, 1, 0, 0, "R11 irq in run");
    irq = 0;
    for (int i = 0; i < 3; i++) tick(2'b00, 0, 1, 0, 0, "R11 flush");

    stop = 1;
    for (int i = 0; i < 3; i++) tick(2'b00, 0, 1, 0, 0, "R12 stop in run");
    stop = 0;
    for (int i = 0; i < 3; i++) tick(2'b00, 0, 1, 0, 0, "R12 flush");

    sleep_wr = 1; sleep_wdata = 1;
    tick(2'b01, 1, 1, 0, 0, "R2 enter sleep fast clock");
    sleep_wr = 0;

    cfg_wr = 1; cfg_pll = 0; cfg_slow = 1;
    tick(2'b01, 1, 1, 0, 0, "R6 cfg write in sleep ignored");
    cfg_wr = 0;

    stop = 1;
    tick(2'b01, 1, 1, 0, 0, "R7 stop sync 1");
    tick(2'b01, 1, 1, 0, 0, "R7 stop sync 2");
    tick(2'b10, 1, 1, 0, 0, "R7 clock stopped");
    tick(2'b10, 1, 1, 0, 0, "R7 held");

    cfg_wr = 1; cfg_pll = 0; cfg_slow = 1;
    tick(2'b10, 1, 1, 0, 0, "R6 cfg write while stopped ignored");
    cfg_wr = 0;

    irq = 1;
    tick(2'b10, 1, 1, 0, 0, "R8 irq while stopped");
    irq = 0;
    for (int i = 0; i < 4; i++) tick(2'b10, 1, 1, 0, 0, "R8 irq ignored");

    stop = 0;
    tick(2'b10, 1, 1, 0, 0, "R8 release sync 1");
    tick(2'b10, 1, 1, 0, 0, "R8 release sync 2");
    tick(2'b01, 1, 1, 0, 0, "R8 back to sleep not run");
    tick(2'b01, 1, 1, 0, 0, "R8 stays asleep");

    irq = 1;
    tick(2'b01, 1, 1, 0, 0, "R4 irq sync 1");
    tick(2'b01, 1, 1, 0, 0, "R4 irq sync 2");
    tick(2'b00, 0, 1, 0, 1, "R4 R5 wake");
    tick(2'b00, 0, 1, 0, 0, "R4 wake pulse one cycle R6 config kept");
    irq = 0;
    for (int i = 0; i < 3; i++) tick(2'b00, 0, 1, 0, 0, "R4 flush");

    cfg_wr = 1; cfg_pll = 1; cfg_slow = 1;
    tick(2'b00, 0, 1, 1, 0, "R9 select slow clock");
    cfg_wr = 0;
    sleep_wr = 1; sleep_wdata = 1;
    tick(2'b01, 1, 1, 1, 0, "R9 enter sleep slow clock");
    sleep_wr = 0;

    irq = 1; stop = 1;
    tick(2'b01, 1, 1, 1, 0, "R10 sync 1");
    tick(2'b01, 1, 1, 1, 0, "R10 sync 2");
    tick(2'b00, 0, 1, 1, 1, "R10 irq beats stop");
    tick(2'b00, 0, 1, 1, 0, "R10 R12 stop ignored in run");
    irq = 0; stop = 0;
    for (int i = 0; i < 3; i++) tick(2'b00, 0, 1, 1, 0, "R12 final");

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule